// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and decides which one the core should service next. There are five vectors. Two come from active-low external pins, two from timer overflow pulses, and one is shared between a serial-port flag and a non-volatile-memory flag. Each vector has its own enable bit and its own priority bit. One global enable masks all of them.

The external pins can each be set to falling-edge mode or level mode. In edge mode a falling edge is latched as a request. In level mode the request simply follows the pin, so several open-drain sources can share one line. The controller tracks which priority levels are currently in service. A high-level request can therefore interrupt a low-level routine, but nothing can interrupt a high-level routine.

Arbitration happens only on a machine-cycle strobe. When a request wins, the controller raises a one-cycle acknowledge with the vector address. In the same edge it marks the level as busy and clears the hardware-owned flag of the winning source. The serial and memory flags are never cleared by the acknowledge; only explicit clear inputs (software writes) remove them. A return-from-interrupt pulse releases the innermost active level.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Each vector is given an index: pin 0 = 0, timer 0 = 1, pin 1 = 2, timer 1 = 3, serial/memory = 4. The vector address is 0x0003 + 8 × index. Among winners on the same level, the lowest index wins.
- R2: A high-level request is accepted only while no high-level routine is in service. A low-level request is accepted only while neither level is in service.
- R3: While the global enable is 0, no acknowledge occurs, and pending flags are kept.
- R4: A vector whose individual enable bit `src_en_i[index]` is 0 is never acknowledged. Other enabled vectors are still arbitrated normally.
- R5: The memory flag requests vector 4 only when both `ee_en_i` and `src_en_i[4]` are 1.
- R6: The serial flag (`flag_o[4]`) and the memory flag (`flag_o[5]`) are not changed by an acknowledge. They clear only through `flag_clr_i[0]` and `flag_clr_i[1]` respectively, and a set in the same cycle wins.
- R7: The timer flags (`flag_o[1]`, `flag_o[3]`) and the latched edge flags (`flag_o[0]`, `flag_o[2]`) are cleared by the acknowledge of their own vector.
- R8: With `ext_level_i[k]` = 0, a falling edge on `ext_n_i[k]` sets a latched flag two clocks after the pin changes. With `ext_level_i[k]` = 1, the flag shows the inverted pin, delayed by one register, and is never latched.
- R9: A `reti_i` pulse clears the high in-service level if it is set, and otherwise the low one. Arbitration in the same cycle still uses the in-service state from before the release.
- R10: Requests are arbitrated only in cycles where `cyc_i` = 1. `ack_o` is high for exactly the one cycle after that edge, with `vec_o` valid.
- R11: An enabled request whose priority bit `prio_i[index]` = 1 wins over every request with priority 0, whatever their indices.
- R12: After a synchronous reset, `ack_o`, `vec_o` and `flag_o` are all zero and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Machine-cycle strobe; arbitration happens only when this is 1 |
| reti_i | input | 1 | Return from interrupt; releases the innermost active level |
| glb_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | 5 | Per-vector enables, indexed as in R1 |
| ee_en_i | input | 1 | Memory-flag enable (takes effect only with `src_en_i[4]`) |
| prio_i | input | 5 | Per-vector priority: 1 = high level |
| ext_n_i | input | 2 | Active-low external request pins |
| ext_level_i | input | 2 | Per-pin mode: 1 = level, 0 = falling edge |
| tmr_ovf_i | input | 2 | Timer overflow pulses that set the timer flags |
| ser_set_i | input | 1 | Sets the serial flag |
| ee_set_i | input | 1 | Sets the memory flag |
| flag_clr_i | input | 2 | Software clears: bit 0 = serial flag, bit 1 = memory flag |
| ack_o | output | 1 | One-cycle acknowledge |
| vec_o | output | 16 | Vector address of the last acknowledge |
| flag_o | output | 6 | Flags: {memory, serial, timer 1, pin 1, timer 0, pin 0} |

## Verification
The hardest overlap is a return-from-interrupt arriving in the same cycle as an arbitration strobe while a request is waiting behind the level being released. The bench drives `reti_i` and `cyc_i` together in that situation. It expects no acknowledge on that strobe, because the old in-service state still blocks the request, and then expects the acknowledge on the next strobe. A second overlap is a flag's own acknowledge meeting its software-only clear rule. The bench sweeps every combination of priority and request, and after each acknowledge it checks that only the winner's hardware-owned flag has dropped.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_VEC = 5;
  localparam int IDX_W   = 3;
  localparam int SRC_X0  = 0;
  localparam int SRC_T0  = 1;
  localparam int SRC_X1  = 2;
  localparam int SRC_T1  = 3;
  localparam int SRC_SER = 4;

  typedef struct packed {
    logic             hit;
    logic             hi;
    logic [IDX_W-1:0] idx;
  } arb_res_t;
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic level_mode,
  input  logic take,
  output logic req
);
  logic pin_q;
  logic pin_d;
  logic edge_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q     <= 1'b1;
      pin_d     <= 1'b1;
      edge_flag <= 1'b0;
    end else begin
      pin_q <= pin_n;
      pin_d <= pin_q;
      if (level_mode)            edge_flag <= 1'b0;
      else if (pin_d && !pin_q)  edge_flag <= 1'b1;
      else if (take)             edge_flag <= 1'b0;
    end
  end

  assign req = level_mode ? !pin_q : edge_flag;

  AST_LEVEL_NOT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    level_mode |=> !edge_flag); // R8
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int N = NUM_VEC
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] prio,
  input  logic [1:0]   busy,
  output arb_res_t     res
);
  logic hi_ok;
  logic lo_ok;

  assign hi_ok = !busy[1];
  assign lo_ok = (busy == 2'b00);

  always_comb begin
    res = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && !prio[i] && lo_ok) begin
        res.hit = 1'b1;
        res.hi  = 1'b0;
        res.idx = IDX_W'(i);
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && prio[i] && hi_ok) begin
        res.hit = 1'b1;
        res.hi  = 1'b1;
        res.idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       take_hi,
  input  logic       reti,
  output logic [1:0] busy
);
  logic [1:0] nxt;

  always_comb begin
    nxt = busy;
    if (reti) begin
      if (busy[1]) nxt[1] = 1'b0;
      else         nxt[0] = 1'b0;
    end
    if (take) nxt[take_hi] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= 2'b00;
    else     busy <= nxt;
  end

  AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (reti && busy[1] && !take) |=> (!busy[1] && busy[0] == $past(busy[0]))); // R9
  AST_RETI_LO: assert property (@(posedge clk) disable iff (rst)
    (reti && busy == 2'b01 && !take) |=> (busy == 2'b00)); // R9
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          VEC_BASE = 3,
  parameter int          VEC_STEP = 8,
  parameter int          N_EXT    = 2,
  parameter int          N_TMR    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_i,
  input  logic              reti_i,
  input  logic              glb_en_i,
  input  logic [4:0]        src_en_i,
  input  logic              ee_en_i,
  input  logic [4:0]        prio_i,
  input  logic [1:0]        ext_n_i,
  input  logic [1:0]        ext_level_i,
  input  logic [1:0]        tmr_ovf_i,
  input  logic              ser_set_i,
  input  logic              ee_set_i,
  input  logic [1:0]        flag_clr_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [5:0]        flag_o
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(VEC_STEP);
  localparam logic [ADDR_W-1:0] T0_VEC = ADDR_W'(VEC_BASE + SRC_T0 * VEC_STEP);

  logic [N_EXT-1:0]   ext_req;
  logic [N_TMR-1:0]   tmr_flag;
  logic               ser_flag;
  logic               ee_flag;
  logic [NUM_VEC-1:0] req_raw;
  logic [NUM_VEC-1:0] req_en;
  logic [NUM_VEC-1:0] take_vec;
  logic [1:0]         busy;
  arb_res_t           res;
  logic               take;
  logic               ack_hi_q;

  genvar g;
  generate
    for (g = 0; g < N_EXT; g++) begin : g_ext
      irq_ext_sense u_sense (
        .clk        (clk),
        .rst        (rst),
        .pin_n      (ext_n_i[g]),
        .level_mode (ext_level_i[g]),
        .take       (take_vec[2*g]),
        .req        (ext_req[g])
      );
    end
    for (g = 0; g < N_TMR; g++) begin : g_tmr
      always_ff @(posedge clk) begin
        if (rst)                   tmr_flag[g] <= 1'b0;
        else if (tmr_ovf_i[g])     tmr_flag[g] <= 1'b1;
        else if (take_vec[2*g+1])  tmr_flag[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_flag <= 1'b0;
      ee_flag  <= 1'b0;
    end else begin
      if (ser_set_i)          ser_flag <= 1'b1;
      else if (flag_clr_i[0]) ser_flag <= 1'b0;
      if (ee_set_i)           ee_flag  <= 1'b1;
      else if (flag_clr_i[1]) ee_flag  <= 1'b0;
    end
  end

  assign req_raw[SRC_X0]  = ext_req[0];
  assign req_raw[SRC_T0]  = tmr_flag[0];
  assign req_raw[SRC_X1]  = ext_req[1];
  assign req_raw[SRC_T1]  = tmr_flag[1];
  assign req_raw[SRC_SER] = ser_flag | (ee_flag & ee_en_i);
  assign req_en = req_raw & src_en_i & {NUM_VEC{glb_en_i}};

  irq_arbiter #(.N(NUM_VEC)) u_arb (
    .req  (req_en),
    .prio (prio_i),
    .busy (busy),
    .res  (res)
  );

  assign take = cyc_i && res.hit;

  always_comb begin
    take_vec = '0;
    if (take) take_vec[res.idx] = 1'b1;
  end

  irq_level_track u_lvl (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_hi (res.hi),
    .reti    (reti_i),
    .busy    (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o    <= 1'b0;
      ack_hi_q <= 1'b0;
      vec_o    <= '0;
    end else begin
      ack_o    <= take;
      ack_hi_q <= take && res.hi;
      if (take) vec_o <= BASE_V + ({{(ADDR_W-IDX_W){1'b0}}, res.idx} * STEP_V);
    end
  end

  assign flag_o = {ee_flag, ser_flag, tmr_flag[1], ext_req[1], tmr_flag[0], ext_req[0]};

  AST_ACK_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(cyc_i)); // R10
  AST_ACK_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(glb_en_i)); // R3
  AST_NO_HI_NEST: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !$past(busy[1])); // R2
  AST_LO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !ack_hi_q) |-> ($past(busy) == 2'b00)); // R2
  AST_SER_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
    ($past(ser_flag) && !$past(flag_clr_i[0])) |-> ser_flag); // R6
  AST_EE_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
    ($past(ee_flag) && !$past(flag_clr_i[1])) |-> ee_flag); // R6
  AST_TMR_HW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ack_o && vec_o == T0_VEC && !$past(tmr_ovf_i[0])) |-> !tmr_flag[0]); // R7
endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_i = 1'b0, reti_i = 1'b0, glb_en_i = 1'b0, ee_en_i = 1'b0;
  logic [4:0]  src_en_i = '0, prio_i = '0;
  logic [1:0]  ext_n_i = 2'b11, ext_level_i = 2'b00, tmr_ovf_i = 2'b00, flag_clr_i = 2'b00;
  logic        ser_set_i = 1'b0, ee_set_i = 1'b0;
  logic        ack_o;
  logic [15:0] vec_o;
  logic [5:0]  flag_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .reti_i(reti_i), .glb_en_i(glb_en_i),
    .src_en_i(src_en_i), .ee_en_i(ee_en_i), .prio_i(prio_i), .ext_n_i(ext_n_i),
    .ext_level_i(ext_level_i), .tmr_ovf_i(tmr_ovf_i), .ser_set_i(ser_set_i),
    .ee_set_i(ee_set_i), .flag_clr_i(flag_clr_i), .ack_o(ack_o), .vec_o(vec_o),
    .flag_o(flag_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc_i = 0; reti_i = 0; glb_en_i = 0; ee_en_i = 0;
    src_en_i = '0; prio_i = '0; ext_n_i = 2'b11; ext_level_i = '0;
    tmr_ovf_i = '0; ser_set_i = 0; ee_set_i = 0; flag_clr_i = '0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic strobe();
    cyc_i = 1'b1; step(); cyc_i = 1'b0;
  endtask

  task automatic reti_pulse();
    reti_i = 1'b1; step(); reti_i = 1'b0;
  endtask

  function automatic int exp_idx(input logic [4:0] r, input logic [4:0] p);
    for (int i = 0; i < 5; i++) if (r[i] && p[i]) return i;
    for (int i = 0; i < 5; i++) if (r[i]) return i;
    return -1;
  endfunction

  initial begin
    step(1);
    do_reset();
    step(1);
    // R12 reset state
    chk(ack_o == 0, "R12 ack", ack_o, 0);
    chk(vec_o == 0, "R12 vec", vec_o, 0);
    chk(flag_o == 0, "R12 flags", flag_o, 0);

    // Sweep of every priority mask against every request set: R1 R11 R7 R6 R8
    for (int p = 0; p < 32; p++) begin
      for (int r = 1; r < 32; r++) begin
        int w;
        logic [5:0] ef;
        do_reset();
        glb_en_i = 1; src_en_i = 5'h1f; prio_i = p[4:0];
        ext_n_i[0] = !r[0]; ext_n_i[1] = !r[2];
        tmr_ovf_i = {r[3], r[1]}; ser_set_i = r[4];
        step(); tmr_ovf_i = '0; ser_set_i = 0;
        step();
        chk(flag_o[4:0] == r[4:0], "R8 flags latched", flag_o, r);
        strobe();
        w = exp_idx(r[4:0], p[4:0]);
        chk(ack_o == 1, "R11 ack", ack_o, 1);
        chk(vec_o == 16'(3 + 8*w), "R1 vector", vec_o, 3 + 8*w);
        step();
        ef = {1'b0, r[4:0]};
        if (w != 4) ef[w] = 1'b0;
        chk(ack_o == 0, "R10 single cycle", ack_o, 0);
        chk(flag_o == ef, "R7 winner flag cleared", flag_o, ef);
      end
    end

    // R10 no arbitration without strobe
    do_reset();
    glb_en_i = 1; src_en_i = 5'h1f; tmr_ovf_i = 2'b01; step(); tmr_ovf_i = 0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(ack_o == 0, "R10 no strobe", ack_o, 0);
    end

    // Nesting: R2 R9
    do_reset();
    glb_en_i = 1; src_en_i = 5'h1f; prio_i = 5'b00001;
    tmr_ovf_i = 2'b01; step(); tmr_ovf_i = 0; step();
    strobe();
    chk(ack_o == 1 && vec_o == 16'h000B, "R1 low t0", vec_o, 16'h000B);
    tmr_ovf_i = 2'b10; step(); tmr_ovf_i = 0;
    strobe();
    chk(ack_o == 0, "R2 same level blocked", ack_o, 0);
    ext_n_i[0] = 0; step(2);
    strobe();
    chk(ack_o == 1 && vec_o == 16'h0003, "R2 high preempts", vec_o, 16'h0003);
    ext_n_i[0] = 1; prio_i = 5'b00101;
    ext_n_i[1] = 0; step(2); ext_n_i[1] = 1;
    strobe();
    chk(ack_o == 0, "R2 high not nested", ack_o, 0);
    reti_i = 1; cyc_i = 1; step(); reti_i = 0; cyc_i = 0;
    chk(ack_o == 0, "R9 release same cycle uses old state", ack_o, 0);
    strobe();
    chk(ack_o == 1 && vec_o == 16'h0013, "R9 after release", vec_o, 16'h0013);
    reti_pulse();
    strobe();
    chk(ack_o == 0, "R9 only high released", ack_o, 0);
    reti_pulse();
    strobe();
    chk(ack_o == 1 && vec_o == 16'h001B, "R9 low released", vec_o, 16'h001B);

    // R3 global enable
    do_reset();
    src_en_i = 5'h1f; tmr_ovf_i = 2'b01; step(); tmr_ovf_i = 0;
    strobe();
    chk(ack_o == 0, "R3 masked", ack_o, 0);
    chk(flag_o[1] == 1, "R3 flag kept", flag_o[1], 1);
    glb_en_i = 1;
    strobe();
    chk(ack_o == 1 && vec_o == 16'h000B, "R3 unmasked", vec_o, 16'h000B);

    // R4 individual enable
    do_reset();
    glb_en_i = 1; src_en_i = 5'b11101;
    tmr_ovf_i = 2'b11; step(); tmr_ovf_i = 0;
    strobe();
    chk(ack_o == 1 && vec_o == 16'h001B, "R4 disabled skipped", vec_o, 16'h001B);

    // R5 R6 memory flag on shared vector
    do_reset();
    glb_en_i = 1; src_en_i = 5'b01111; ee_en_i = 1;
    ee_set_i = 1; step(); ee_set_i = 0;
    strobe();
    chk(ack_o == 0, "R5 needs serial enable", ack_o, 0);
    src_en_i = 5'h1f;
    strobe();
    chk(ack_o == 1 && vec_o == 16'h0023, "R5 shared vector", vec_o, 16'h0023);
    step();
    chk(flag_o[5] == 1, "R6 memory flag kept after ack", flag_o[5], 1);
    flag_clr_i = 2'b10; step(); flag_clr_i = 0;
    chk(flag_o[5] == 0, "R6 software clear", flag_o[5], 0);
    ser_set_i = 1; flag_clr_i = 2'b01; step(); ser_set_i = 0; flag_clr_i = 0;
    chk(flag_o[4] == 1, "R6 set wins over clear", flag_o[4], 1);
    do_reset();
    glb_en_i = 1; src_en_i = 5'h1f; ee_en_i = 0;
    ee_set_i = 1; step(); ee_set_i = 0;
    strobe();
    chk(ack_o == 0, "R5 memory enable off", ack_o, 0);

    // R8 level mode
    do_reset();
    glb_en_i = 1; src_en_i = 5'h1f; ext_level_i = 2'b01;
    ext_n_i[0] = 0; step();
    chk(flag_o[0] == 1, "R8 level follows pin", flag_o[0], 1);
    ext_n_i[0] = 1; step();
    chk(flag_o[0] == 0, "R8 level not latched", flag_o[0], 0);
    ext_n_i[0] = 0; step();
    strobe();
    chk(ack_o == 1 && vec_o == 16'h0003, "R8 level ack", vec_o, 16'h0003);
    step();
    chk(flag_o[0] == 1, "R8 level survives ack", flag_o[0], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule